// File: doc/BRIEF.md
# Dual-Channel Programmable Interval Timer

This block is a register-mapped interval timer with a parameterized number of independent channels (two by default) that all run from one shared functional clock. Each channel has its own power-of-two prescaler, an up-counter that compares against a programmable period, and a choice between free-running auto-reload and single-expiry operation. When a period ends, the channel sets a sticky status flag that software clears by writing a one. The interrupt line goes high while any channel has a set flag with its interrupt enable on.

Software reaches the block through a simple word-aligned byte-address bus. Writes are single-cycle strobes. Read data is combinational from the address. Each channel owns a 128-byte window. Channel c sits at base 0x80 × (c + 1). Inside the window, control is at +0x0, status at +0x4, period at +0x8 and the live count at +0xC.

Top module: `pit_top`

## Requirements
- R1: After reset every control register reads 0, every status register reads 0, every period register reads 0xFFFF, every count reads 0 and `irq` is low.
- R2: Only bits 8 (interrupt enable), 5 (run enable), 4 (single-expiry select) and 3:0 (prescale code) of a control register are stored; other bits read 0. A read from any address that is not one of the four registers of an existing channel returns 0.
- R3: With prescale code n (0 to 8) and period value L, a channel enabled at clock edge E first expires at edge E + (L+1)·2^n. Codes 9 to 15 behave like code 8 (divide by 256).
- R4: With bit 4 clear, the count restarts from 0 after each expiry and the channel expires again every (L+1)·2^n clocks while it stays enabled.
- R5: With bit 4 set, the expiry clears the run-enable bit (control then reads without bit 5), the count returns to 0 and stays there.
- R6: Status bit 0 is set on every expiry whether or not the interrupt is enabled. Writing 1 to bit 0 clears it. Writing 0 leaves it set.
- R7: `irq` is high exactly when some channel has status bit 0 set and its control bit 8 set.
- R8: Writing the period register, or writing the control register with bit 5 set while the channel is stopped, restarts the count and the prescaler phase from zero.
- R9: Writes to a count register are ignored, and a write to one channel changes no register of another channel.
- R10: A stopped channel holds its count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (12) | Byte address of the register accessed |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR over channels of status and enable |

## Verification
The bench uses the default parameters: two channels, 16-bit registers and a maximum prescale exponent of 8. With two channels the bench can test channel isolation and the decode of the window just past the last channel. With the full exponent range, a reserved prescale code gives a 256-clock period that the bench reaches and counts edge by edge. Short periods at divide-by-1 and divide-by-2 let the bench check the expiry edge, the auto-reload repeat and the single-expiry stop to the exact cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Control bit positions; the prescale code sits in bits 3:0.
   localparam int CTL_IE_BIT = 8;
   localparam int CTL_EN_BIT = 5;
   localparam int CTL_OS_BIT = 4;
   localparam int CODE_W     = 4;

   // Register window layout inside one channel slot.
   localparam int WIN_LSB = 7;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_STS  = 2'd1,
      REG_LOAD = 2'd2,
      REG_CNT  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PRE_MAX = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [3:0] code,
   output logic       tick
);
   localparam int PCW = (PRE_MAX > 0) ? PRE_MAX : 1;

   initial begin
      if (PRE_MAX < 0 || PRE_MAX > 15)
         $error("pit_prescaler: PRE_MAX must be within 0..15");
   end

   generate
      if (PRE_MAX == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [3:0]     eff;
         logic [PCW-1:0] lim;
         logic [PCW-1:0] phase_q;

         always_comb begin
            eff = (code > 4'(PRE_MAX)) ? 4'(PRE_MAX) : code;
            lim = PCW'((32'd1 << eff) - 32'd1);
         end

         assign tick = run && (phase_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase_q <= '0;
            else if (restart) phase_q <= '0;
            else if (run)     phase_q <= tick ? '0 : phase_q + 1'b1;
         end

         a_r8_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (phase_q == '0));
      end
   endgenerate
endmodule

// File: rtl/pit_decode.sv
module pit_decode
   import pit_pkg::*;
#(
   parameter int N_CH = 2,
   parameter int AW   = 12
) (
   input  logic [AW-1:0]   addr,
   output logic [N_CH-1:0] hit,
   output reg_sel_e        sel
);
   localparam int SW = AW - WIN_LSB;

   logic [SW-1:0]      slot;
   logic [WIN_LSB-1:0] off;
   logic               off_ok;

   assign slot   = addr[AW-1:WIN_LSB];
   assign off    = addr[WIN_LSB-1:0];
   assign off_ok = (off[WIN_LSB-1:4] == '0) && (off[1:0] == 2'b00);
   assign sel    = reg_sel_e'(off[3:2]);

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_hit
         assign hit[c] = off_ok && (slot == SW'(c + 1));
      end
   endgenerate
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int DW      = 16,
   parameter int CNT_W   = 16,
   parameter int PRE_MAX = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic          sts_wr,
   input  logic          load_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctl_rd,
   output logic [DW-1:0] sts_rd,
   output logic [DW-1:0] load_rd,
   output logic [DW-1:0] cnt_rd,
   output logic          irq_req
);
   logic              ie_q, en_q, os_q, sts_q;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  load_q, count_q;
   logic              restart, tick, expire;

   assign restart = load_wr || (ctl_wr && wdata[CTL_EN_BIT] && !en_q);
   assign expire  = tick && (count_q == load_q);

   pit_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (restart),
      .code    (code_q),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         en_q   <= 1'b0;
         os_q   <= 1'b0;
         code_q <= '0;
      end else if (ctl_wr) begin
         ie_q   <= wdata[CTL_IE_BIT];
         en_q   <= wdata[CTL_EN_BIT];
         os_q   <= wdata[CTL_OS_BIT];
         code_q <= wdata[CODE_W-1:0];
      end else if (expire && os_q) begin
         en_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       load_q <= '1;
      else if (load_wr) load_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (restart) count_q <= '0;
      else if (tick)    count_q <= expire ? '0 : count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sts_q <= 1'b0;
      else if (expire)            sts_q <= 1'b1;
      else if (sts_wr && wdata[0]) sts_q <= 1'b0;
   end

   always_comb begin
      ctl_rd                = '0;
      ctl_rd[CTL_IE_BIT]    = ie_q;
      ctl_rd[CTL_EN_BIT]    = en_q;
      ctl_rd[CTL_OS_BIT]    = os_q;
      ctl_rd[CODE_W-1:0]    = code_q;
      sts_rd                = DW'(sts_q);
      load_rd               = DW'(load_q);
      cnt_rd                = DW'(count_q);
   end

   assign irq_req = sts_q && ie_q;

   a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && os_q && !ctl_wr) |=> !en_q);
   a_r6_expiry_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> sts_q);
   a_r4_count_within_period: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= load_q);
   a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !load_wr && !ctl_wr) |=> $stable(count_q));
endmodule

// File: rtl/pit_top.sv
module pit_top
   import pit_pkg::*;
#(
   parameter int N_CH    = 2,
   parameter int DW      = 16,
   parameter int CNT_W   = 16,
   parameter int PRE_MAX = 8,
   parameter int AW      = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   initial begin
      if (N_CH < 1) $error("pit_top: N_CH must be at least 1");
      if (DW < CTL_IE_BIT + 1) $error("pit_top: DW too narrow for control bits");
      if (CNT_W < 1 || CNT_W > DW) $error("pit_top: CNT_W must be 1..DW");
      if ((N_CH + 1) * (1 << WIN_LSB) > (1 << AW))
         $error("pit_top: AW too narrow for N_CH windows");
   end

   logic [N_CH-1:0] hit;
   reg_sel_e        sel;
   logic [N_CH-1:0] irq_vec;
   logic [DW-1:0]   ch_rd [N_CH];

   pit_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .sel  (sel)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic [DW-1:0] r_ctl, r_sts, r_load, r_cnt;
         logic          wr_here;

         assign wr_here = bus_wr && hit[c];

         pit_channel #(.DW(DW), .CNT_W(CNT_W), .PRE_MAX(PRE_MAX)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (wr_here && (sel == REG_CTL)),
            .sts_wr  (wr_here && (sel == REG_STS)),
            .load_wr (wr_here && (sel == REG_LOAD)),
            .wdata   (bus_wdata),
            .ctl_rd  (r_ctl),
            .sts_rd  (r_sts),
            .load_rd (r_load),
            .cnt_rd  (r_cnt),
            .irq_req (irq_vec[c])
         );

         always_comb begin
            unique case (sel)
               REG_CTL:  ch_rd[c] = r_ctl;
               REG_STS:  ch_rd[c] = r_sts;
               REG_LOAD: ch_rd[c] = r_load;
               default:  ch_rd[c] = r_cnt;
            endcase
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < N_CH; c++)
         if (hit[c]) bus_rdata = bus_rdata | ch_rd[c];
   end

   assign irq = |irq_vec;

   a_r2_single_window: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/pit_top_test.sv
module pit_top_test;
   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int n_tests = 0;
   int n_fail  = 0;
   logic rd_valid = 1'b0;
   bit   finished = 1'b0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } exp_item_t;
   exp_item_t sb_q[$];

   always #5 clk = ~clk;

   pit_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // Monitor: compares each read against the expected item queued by the driver.
   always @(negedge clk) begin
      if (rd_valid) begin
         exp_item_t it;
         it = sb_q.pop_front();
         n_tests++;
         if (bus_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: read 0x%03h got 0x%04h expected 0x%04h",
                     it.tag, bus_addr, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      exp_item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      rd_valid = 1'b1;
      @(negedge clk); #1;
      rd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      n_tests++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
      end
   endtask

   localparam logic [AW-1:0] C0_CTL = 12'h080, C0_STS = 12'h084,
                             C0_LD  = 12'h088, C0_CNT = 12'h08C;
   localparam logic [AW-1:0] C1_CTL = 12'h100, C1_STS = 12'h104,
                             C1_LD  = 12'h108, C1_CNT = 12'h10C;

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R1 reset values
      chk_irq(1'b0, "R1 irq after reset");
      rd(C0_CTL, 16'h0000, "R1 ctl0 reset");
      rd(C0_STS, 16'h0000, "R1 sts0 reset");
      rd(C0_LD,  16'hFFFF, "R1 load0 reset");
      rd(C0_CNT, 16'h0000, "R1 cnt0 reset");
      rd(C1_LD,  16'hFFFF, "R1 load1 reset");

      // R2 register map, masked control, unmapped reads
      wr(C0_LD, 16'h1234);
      rd(C0_LD, 16'h1234, "R2 load readback");
      wr(C0_CTL, 16'hFEC8);
      rd(C0_CTL, 16'h0008, "R2 control keeps only defined bits");
      wr(C0_CTL, 16'h0000);
      rd(12'h000, 16'h0000, "R2 window below channel 0");
      rd(12'h090, 16'h0000, "R2 offset past count");
      rd(12'h086, 16'h0000, "R2 misaligned offset");
      rd(12'h180, 16'h0000, "R2 window past last channel");

      // R3 / R4 auto-reload, period 4 ticks at divide-by-2 -> 8 clocks
      wr(C0_LD, 16'h0003);
      wr(C0_CTL, 16'h0021);                 // enable edge E
      idle(6);
      rd(C0_STS, 16'h0000, "R3 no expiry one edge early");
      rd(C0_STS, 16'h0001, "R3 expiry at E+8");
      wr(C0_STS, 16'h0001);                 // cleared at E+10
      rd(C0_STS, 16'h0000, "R6 write-one clears status");
      rd(C0_CNT, 16'h0002, "R4 count restarted from zero");
      idle(3);
      rd(C0_STS, 16'h0001, "R4 second expiry at E+16");

      // R10 stop holds count
      wr(C0_CTL, 16'h0001);
      rd(C0_CNT, 16'h0001, "R10 count at stop");
      idle(5);
      rd(C0_CNT, 16'h0001, "R10 count held while stopped");

      // R6 / R7 status independent of IE, irq gating
      chk_irq(1'b0, "R7 status set but interrupt disabled");
      wr(C0_CTL, 16'h0101);
      chk_irq(1'b1, "R7 enable raises irq");
      wr(C0_STS, 16'h0000);
      rd(C0_STS, 16'h0001, "R6 writing zero keeps status");
      wr(C0_STS, 16'h0001);
      chk_irq(1'b0, "R7 clear drops irq");
      rd(C0_STS, 16'h0000, "R6 status cleared");

      // R5 one-shot, period 3 clocks at divide-by-1
      wr(C0_LD, 16'h0002);
      wr(C0_CTL, 16'h0130);                 // edge E
      idle(1);
      rd(C0_STS, 16'h0000, "R5 no expiry at E+2");
      rd(C0_STS, 16'h0001, "R5 expiry at E+3");
      chk_irq(1'b1, "R7 one-shot expiry raises irq");
      rd(C0_CTL, 16'h0110, "R5 enable cleared after expiry");
      rd(C0_CNT, 16'h0000, "R5 count back at zero");
      idle(10);
      rd(C0_CNT, 16'h0000, "R5 count stays at zero");
      rd(C0_STS, 16'h0001, "R5 single expiry status stays");
      wr(C0_STS, 16'h0001);

      // R8 period write restarts count and prescaler phase
      wr(C0_LD, 16'h0005);
      wr(C0_CTL, 16'h0021);                 // edge E
      idle(4);
      wr(C0_LD, 16'h0005);                  // edge W = E+6
      idle(10);
      rd(C0_STS, 16'h0000, "R8 old schedule at W+6 cancelled");
      rd(C0_STS, 16'h0001, "R8 expiry at W+12");
      wr(C0_CTL, 16'h0000);
      wr(C0_STS, 16'h0001);
      rd(C0_STS, 16'h0000, "R8 status cleared after stop");

      // R3 reserved code 15 behaves as divide-by-256
      wr(C1_LD, 16'h0000);
      wr(C1_CTL, 16'h002F);                 // edge E
      idle(254);
      rd(C1_STS, 16'h0000, "R3 reserved code no expiry at E+255");
      rd(C1_STS, 16'h0001, "R3 reserved code expiry at E+256");

      // R9 count writes ignored, channels isolated
      wr(C0_LD, 16'h0007);
      wr(C0_CNT, 16'h5555);
      rd(C0_CNT, 16'h0000, "R9 count write ignored");
      rd(C0_LD, 16'h0007, "R9 count write left period alone");
      rd(C0_CTL, 16'h0000, "R9 channel 0 control untouched by channel 1");
      rd(C1_CTL, 16'h002F, "R9 channel 1 control untouched by channel 0");

      // R7 second channel drives irq
      wr(C1_CTL, 16'h012F);
      chk_irq(1'b1, "R7 channel 1 status with enable");
      wr(C1_CTL, 16'h0000);
      wr(C1_STS, 16'h0001);
      chk_irq(1'b0, "R7 channel 1 cleared");

      idle(2);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule